// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler with Two Field Formats

This block turns a prescale field from the SPI configuration register into a one-cycle enable pulse. The SPI shifter uses that pulse to toggle its serial clock. The pulse comes once every half period of the serial clock and is counted in core-clock cycles.

A format-select input picks how the 8-bit field is read:

- **Legacy format.** A flag bit plus a 4-bit count gives an even divisor.
- **Extended format.** A 4-bit mantissa is shifted left by a 3-bit exponent. The exponent bits are spread over non-contiguous positions of the field.

Both formats reduce to one divide ratio, and one counter produces the pulses from it. Pulses appear only while the transfer-active input is high. Dropping that input resets the count, so the next transfer starts on a clean half period.

When the divide ratio is odd, the two halves of each serial-clock period are one cycle apart in length. This keeps the full period exact. The block does not work out field values from a requested bit rate, and it does not include the shifter.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While reset is asserted and at the first edge after it is released, `half_tick` is 0.
- R2: While `xfer_active` is low, `half_tick` stays 0, and it is 0 in the cycle after any edge at which `xfer_active` was sampled low.
- R3: Legacy format (`ext_fmt` = 0). When field bit 4 is 1 and bits 3:0 hold n with n from 2 to 15, the divisor is 2·n. Bits 7:6 are ignored in this format.
- R4: Legacy format with bit 4 clear, or with n below 2, gives the minimum divisor of 4.
- R5: Extended format (`ext_fmt` = 1). The divisor is m·2^e. The mantissa m is bits 3:0. The exponent e is {bit 7, bit 6, bit 4}, with bit 4 as its least significant bit. The largest divisor is 15·2^7 = 1920.
- R6: Extended format with mantissa 0, or with a product below 4, gives the minimum divisor of 4.
- R7: For a divisor D, after a start the intervals between successive pulses alternate. The first interval is floor(D/2) cycles, the next is D − floor(D/2) cycles, and so on. Every pair of intervals therefore totals exactly D.
- R8: Field bit 5 has no effect on the divisor in either format.
- R9: The first pulse comes exactly floor(D/2) cycles after `xfer_active` rises. This holds even when a previous transfer was cut off partway through a half period.
- R10: Each pulse lasts exactly one core-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_fmt | input | 1 | 0 selects the legacy field layout, 1 the extended layout |
| prescale_cfg | input | 8 | Prescale field from the configuration register |
| xfer_active | input | 1 | High while a transfer is in progress |
| half_tick | output | 1 | One-cycle pulse once per serial-clock half period |

## Verification
`half_tick` is registered. If `xfer_active` is first sampled high at edge E0, the first pulse is visible just after edge E(floor(D/2)−1), and each later pulse follows one interval length after the previous one. The bench changes inputs and samples outputs only on falling edges. It counts the falling edges from raising `xfer_active` to the first pulse, and then between the first and second pulses. It compares those two counts with floor(D/2) and D − floor(D/2), where D is written by hand in the vector table. One falling edge after each pulse, the bench checks that the pulse has dropped. Two falling edges after `xfer_active` falls, it checks that no pulse is present.

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler #(
  parameter int CFG_W   = 8,
  parameter int DIV_W   = 11,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_fmt,
  input  logic [CFG_W-1:0] prescale_cfg,
  input  logic             xfer_active,
  output logic             half_tick
);

  localparam logic [DIV_W-1:0] MIN_D = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);

  logic [3:0]       mant;
  logic [2:0]       expo;
  logic [DIV_W-1:0] leg_div, ext_div, raw_div, div;
  logic [DIV_W-1:0] half_lo, half_hi, half_len;
  logic [DIV_W-1:0] cnt;
  logic             phase;
  logic             tick_q;

  assign mant = prescale_cfg[3:0];
  assign expo = {prescale_cfg[7:6], prescale_cfg[4]};

  assign leg_div = prescale_cfg[4] ? DIV_W'({mant, 1'b0}) : '0;
  assign ext_div = DIV_W'(mant) << expo;
  assign raw_div = ext_fmt ? ext_div : leg_div;
  assign div     = (raw_div < MIN_D) ? MIN_D : raw_div;

  assign half_lo  = div >> 1;
  assign half_hi  = div - half_lo;
  assign half_len = phase ? half_hi : half_lo;

  always_ff @(posedge clk) begin
    if (!rst_n || !xfer_active) begin
      cnt    <= ONE;
      phase  <= 1'b0;
      tick_q <= 1'b0;
    end else if (cnt >= half_len) begin
      cnt    <= ONE;
      phase  <= ~phase;
      tick_q <= 1'b1;
    end else begin
      cnt    <= cnt + ONE;
      tick_q <= 1'b0;
    end
  end

  assign half_tick = tick_q;

endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_active,
  input logic half_tick
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> !half_tick);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> !half_tick);

  // R9
  start_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_active) |=> !half_tick);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick);

endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_active (xfer_active),
  .half_tick   (half_tick)
);

// File: tb/spi_sclk_prescaler_tb_top.sv
module spi_sclk_prescaler_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_fmt = 1'b0;
  logic [7:0] prescale_cfg = 8'h00;
  logic       xfer_active = 1'b0;
  logic       half_tick;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_sclk_prescaler dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_fmt      (ext_fmt),
    .prescale_cfg (prescale_cfg),
    .xfer_active  (xfer_active),
    .half_tick    (half_tick)
  );

  // {ext_fmt, field, expected divisor}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 8'h12, 12'd4},    // R3 n=2
    {1'b0, 8'h1F, 12'd30},   // R3 max
    {1'b0, 8'h17, 12'd14},   // R3
    {1'b0, 8'h11, 12'd4},    // R4 n=1 clamps
    {1'b0, 8'h07, 12'd4},    // R4 flag clear
    {1'b0, 8'h37, 12'd14},   // R8 bit5 set
    {1'b0, 8'hD5, 12'd10},   // R3 bits 7:6 ignored
    {1'b1, 8'h05, 12'd5},    // R7 odd 2/3
    {1'b1, 8'h0F, 12'd15},   // R7 odd 7/8
    {1'b1, 8'h13, 12'd6},    // R5 e=1
    {1'b1, 8'hCF, 12'd960},  // R5 e=6
    {1'b1, 8'hDF, 12'd1920}, // R5 max
    {1'b1, 8'h10, 12'd4},    // R6 mantissa 0
    {1'b1, 8'h02, 12'd4},    // R6 product 2
    {1'b1, 8'h3F, 12'd30},   // R8 bit5 set
    {1'b1, 8'h47, 12'd28}    // R5 e=2
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!half_tick && n < 4000);
  endtask

  task automatic run_vec(input logic f, input logic [7:0] c, input int dv, input string tag);
    int lo, hi, n;
    lo = dv / 2;
    hi = dv - lo;
    ext_fmt = f;
    prescale_cfg = c;
    xfer_active = 1'b1;
    wait_tick(n);
    check(n == lo, {tag, " first interval (R9)"}, n, lo);
    @(negedge clk);
    check(!half_tick, "R10 pulse width", int'(half_tick), 0);
    n = 1;
    while (!half_tick && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(n == hi, {tag, " second interval (R7)"}, n, hi);
    xfer_active = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!half_tick, "R2 idle after stop", int'(half_tick), 0);
  endtask

  initial begin
    int n;
    int seen;
    @(negedge clk);
    @(negedge clk);
    check(!half_tick, "R1 in reset", int'(half_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!half_tick, "R1 after release", int'(half_tick), 0);

    // R2: configured but idle for many cycles
    ext_fmt = 1'b0;
    prescale_cfg = 8'h12;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (half_tick) seen++;
    end
    check(seen == 0, "R2 no pulse while idle", seen, 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i][20], VEC[i][19:12], int'(VEC[i][11:0]),
              VEC[i][20] ? "R5 extended" : "R3 legacy");
    end

    // R9: abort partway through a half period, then restart
    ext_fmt = 1'b1;
    prescale_cfg = 8'h0F;
    xfer_active = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    xfer_active = 1'b0;
    @(negedge clk);
    xfer_active = 1'b1;
    wait_tick(n);
    check(n == 7, "R9 restart after abort", n, 7);
    xfer_active = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R1: reset in the middle of a transfer
    xfer_active = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!half_tick, "R1 mid-transfer reset", int'(half_tick), 0);
    rst_n = 1'b1;
    wait_tick(n);
    check(n == 7, "R9 first pulse after reset", n, 7);
    xfer_active = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule